// File: doc/BRIEF.md
# Two-Wire Programmer Host Sequencer

This block is the programmer end of a two-wire serial port: one clock line that the host always drives, and one bidirectional data line. A client hands it a request made of a 2-bit command and, for the two host-to-target commands, a 32-bit payload. The block turns the request into one frame on the wire. The frame is the command followed by 32 data bits, each sent least significant bit first. It then raises a one-cycle completion pulse. For the two target-to-host commands, the same pulse comes with the 32 bits that were returned.

The serial clock comes from the system clock. Each high phase and each low phase lasts a programmable number of system clocks. The data line changes only in the middle of a low phase, which leaves a margin before and after every rising edge. On read commands the host releases the line once the command has been sent. It samples each returned bit in the middle of the high phase, which falls after the rising edge and before the next falling edge, the edge on which the target changes the line.

Top module: `twp_host_seq`

## Requirements
- R1: A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while idle, and `busy` is high from the cycle after acceptance until the cycle `done` pulses.
- R2: `sclk` stays low while idle. During a frame, every high phase and every low phase between two high phases lasts exactly the effective half-period, counted in system clocks.
- R3: Each frame has exactly 34 rising edges of `sclk`. The line value at rising edges 1 and 2 is command bit 0 and then command bit 1.
- R4: `sdat_o` changes only while `sclk` is low and was also low in the previous system clock.
- R5: Command bit 0 chooses the direction: 0 (codes 00 and 10) sends `req_data` to the target, and 1 (codes 01 and 11) reads from it. On a send, rising edge 3+i carries `req_data[i]` with `sdat_oe` high.
- R6: On a read, `sdat_oe` is high at rising edges 1 and 2 and low at rising edges 3 to 34. It is high again when `done` pulses. At all other times it is high.
- R7: On a read, `rd_data[i]` is the value of `sdat_i` during the high phase that starts at rising edge 3+i.
- R8: `done` is a one-cycle pulse, given once per frame when the last high phase ends. `rd_data` is updated only by reads and keeps its value across sends.
- R9: A `req_valid` raised while busy is ignored: the frame in flight is not altered and no extra frame follows.
- R10: After reset: `sclk`=0, `sdat_oe`=1, `busy`=0, `req_ready`=1, `done`=0, `rd_data`=0.
- R11: `half_per` is captured when a request is taken, and values 0 and 1 are treated as 2. Changing `half_per` during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_per | input | HP_W | Serial clock half-period in system clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_cmd | input | 2 | Command code; bit 0 set means read |
| req_data | input | DATA_W | Payload for send commands |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word returned by the last read |
| sclk | output | 1 | Serial clock to target |
| sdat_o | output | 1 | Serial data driven by the host |
| sdat_oe | output | 1 | Output enable for `sdat_o` |
| sdat_i | input | 1 | Serial data seen on the line |

## Verification
All four command codes are used, with random payloads and with the all-zeros and all-ones words. The two read codes separate correct direction decoding from decoding of the wrong command bit. A bench target puts random words on the line during reads and random noise just before the first data bit. This shows whether capture starts on the right edge and keeps the right bit order. Half-periods of 0, 1, 2 and up to 7 exercise the clamp and the placement of the data change in short and in long phases. A request raised while busy and a change of `half_per` during a frame check that both are ignored.

// File: rtl/twp_pkg.sv
`timescale 1ns/1ps
package twp_pkg;
    localparam int CMD_W = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;
endpackage

// File: rtl/twp_phase_timer.sv
`timescale 1ns/1ps
// Serial clock generator: alternating low/high phases of half_per system clocks.
module twp_phase_timer #(
    parameter int HP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [HP_W-1:0] half_per,
    output logic            sclk,
    output logic            ev_mid_low,
    output logic            ev_mid_high,
    output logic            ev_end_high
);
    typedef struct packed {
        logic [HP_W-1:0] cnt;
        logic            hi;
    } tmr_t;

    tmr_t q, d;
    logic            last;
    logic [HP_W-1:0] mid;

    always_comb begin
        d    = q;
        last = (q.cnt == half_per - 1'b1);
        mid  = (half_per - 1'b1) >> 1;
        if (!run) begin
            d = '0;
        end else if (last) begin
            d.cnt = '0;
            d.hi  = ~q.hi;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk        = q.hi;
    assign ev_mid_low  = run && !q.hi && (q.cnt == mid);
    assign ev_mid_high = run &&  q.hi && (q.cnt == mid);
    assign ev_end_high = run &&  q.hi && last;
endmodule

// File: rtl/twp_tx_shift.sv
`timescale 1ns/1ps
// Outgoing frame register; presents one bit per shift, LSB first.
module twp_tx_shift #(
    parameter int FRAME_W = 34
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               shift_en,
    output logic               sdo
);
    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic               bit_out;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.sh = frame;
        end else if (shift_en) begin
            d.bit_out = q.sh[0];
            d.sh      = q.sh >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo = q.bit_out;
endmodule

// File: rtl/twp_rx_shift.sv
`timescale 1ns/1ps
// Incoming word register; first captured bit ends up in bit 0.
module twp_rx_shift #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              sdi,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] word_q, word_d;

    always_comb begin
        word_d = word_q;
        if (cap_en) word_d = {sdi, word_q[DATA_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;
endmodule

// File: rtl/twp_host_seq.sv
`timescale 1ns/1ps
module twp_host_seq #(
    parameter int DATA_W = 32,
    parameter int HP_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HP_W-1:0]   half_per,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              sdat_o,
    output logic              sdat_oe,
    input  logic              sdat_i
);
    import twp_pkg::*;

    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int SLOT_W  = $clog2(FRAME_W);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_W - 1);
    localparam logic [SLOT_W-1:0] CMD_LAST  = SLOT_W'(CMD_W - 1);
    localparam logic [SLOT_W-1:0] DATA_FIRST = SLOT_W'(CMD_W);
    localparam logic [HP_W-1:0]   HP_MIN    = HP_W'(2);

    typedef struct packed {
        seq_st_e           st;
        logic [SLOT_W-1:0] slot;
        logic              is_rd;
        logic              oe;
        logic              done;
        logic [HP_W-1:0]   hp;
        logic [DATA_W-1:0] rd;
    } seq_t;

    seq_t q, d;

    logic              run;
    logic              accept;
    logic              ev_mid_low, ev_mid_high, ev_end_high;
    logic              cap_en;
    logic [DATA_W-1:0] rx_word;
    logic [FRAME_W-1:0] frame;

    assign run    = (q.st == ST_RUN);
    assign accept = (q.st == ST_IDLE) && req_valid;
    assign frame  = {(req_cmd[0] ? {DATA_W{1'b0}} : req_data), req_cmd};
    assign cap_en = run && q.is_rd && ev_mid_high && (q.slot >= DATA_FIRST);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_RUN;
                    d.slot  = '0;
                    d.is_rd = req_cmd[0];
                    d.hp    = (half_per < HP_MIN) ? HP_MIN : half_per;
                end
            end
            ST_RUN: begin
                if (ev_end_high) begin
                    if (q.slot == LAST_SLOT) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.oe   = 1'b1;
                        if (q.is_rd) d.rd = rx_word;
                    end else begin
                        d.slot = q.slot + 1'b1;
                        if (q.is_rd && (q.slot == CMD_LAST)) d.oe = 1'b0;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.oe <= 1'b1;
            q.hp <= HP_MIN;
        end else begin
            q <= d;
        end
    end

    twp_phase_timer #(.HP_W(HP_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .half_per   (q.hp),
        .sclk       (sclk),
        .ev_mid_low (ev_mid_low),
        .ev_mid_high(ev_mid_high),
        .ev_end_high(ev_end_high)
    );

    twp_tx_shift #(.FRAME_W(FRAME_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .frame   (frame),
        .shift_en(ev_mid_low),
        .sdo     (sdat_o)
    );

    twp_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_en(cap_en),
        .sdi   (sdat_i),
        .word  (rx_word)
    );

    assign req_ready = (q.st == ST_IDLE);
    assign busy      = run;
    assign done      = q.done;
    assign rd_data   = q.rd;
    assign sdat_oe   = q.oe;
endmodule

// File: rtl/twp_host_seq_chk.sv
`timescale 1ns/1ps
module twp_host_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic sdat_o,
    input logic sdat_oe
);
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    p_rise_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> busy);

    p_sdo_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdat_o) |-> (!sclk && !$past(sclk)));

    p_oe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sdat_oe);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !busy));

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> !req_ready);
endmodule

bind twp_host_seq twp_host_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .busy     (busy),
    .done     (done),
    .sclk     (sclk),
    .sdat_o   (sdat_o),
    .sdat_oe  (sdat_oe)
);

// File: tb/sim_twp_host_seq.sv
`timescale 1ns/1ps
module sim_twp_host_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] half_per = 16'd2;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_cmd = 2'b00;
    logic [31:0] req_data = '0;
    logic        busy, done, sclk, sdat_o, sdat_oe;
    logic [31:0] rd_data;
    logic        sdat_i = 1'b0;

    always #2.5 clk = ~clk;

    twp_host_seq u0 (
        .clk(clk), .rst_n(rst_n), .half_per(half_per),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_data(req_data),
        .busy(busy), .done(done), .rd_data(rd_data),
        .sclk(sclk), .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i)
    );

    int nchk = 0;
    int nbad = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_read(input logic [1:0] cmd);
        return cmd[0];
    endfunction

    function automatic int eff_hp(input int hp);
        return (hp < 2) ? 2 : hp;
    endfunction

    // bench-side target model and line monitor
    logic        rec_bit [0:33];
    logic        rec_oe  [0:33];
    int          rise_cnt = 0;
    int          run_len = 0;
    int          done_cnt = 0;
    int          hp_exp = 2;
    bit          have_fall = 0;
    bit          cur_rd = 0;
    logic [31:0] rbits = '0;
    logic        prev_sclk = 1'b0;
    logic        prev_sdo = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sdat_o !== prev_sdo)
                chk(!sclk && !prev_sclk, "R4", "data moved near clock edge", {31'd0, sclk}, 32'd0);
            if (sclk !== prev_sclk) begin
                if (sclk) begin
                    if (have_fall)
                        chk(run_len == hp_exp, "R2 R11", "low phase length", run_len, hp_exp);
                    if (rise_cnt < 34) begin
                        rec_bit[rise_cnt] = sdat_o;
                        rec_oe[rise_cnt]  = sdat_oe;
                    end
                    rise_cnt++;
                end else begin
                    chk(run_len == hp_exp, "R2 R11", "high phase length", run_len, hp_exp);
                    have_fall = 1;
                    if (cur_rd && rise_cnt >= 2 && rise_cnt < 34)
                        sdat_i = rbits[rise_cnt-2];
                    else
                        sdat_i = 1'($urandom % 2);
                end
                run_len = 1;
            end else begin
                run_len++;
            end
            if (done) done_cnt++;
            prev_sclk = sclk;
            prev_sdo  = sdat_o;
        end
    end

    logic [31:0] exp_rd = '0;

    task automatic run_txn(input logic [1:0] cmd, input logic [31:0] data,
                           input int hp, input logic [31:0] rb, input bit poke);
        int n;
        int bad_cmd, bad_dat, bad_oe;
        @(negedge clk);
        hp_exp = eff_hp(hp);
        rise_cnt = 0; have_fall = 0; done_cnt = 0;
        rbits = rb; cur_rd = is_read(cmd);
        chk(req_ready == 1'b1, "R1", "ready while idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_cmd = cmd; req_data = data; half_per = 16'(hp);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R1", "busy after accept", {31'd0, busy}, 32'd1);
        half_per = 16'($urandom % 9);   // must not affect this frame (R11)
        if (poke) begin
            repeat (5) @(negedge clk);
            req_valid = 1'b1; req_cmd = ~cmd; req_data = ~data;
            @(negedge clk);
            chk(req_ready == 1'b0, "R9", "ready low while busy", {31'd0, req_ready}, 32'd0);
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R8", "done seen before timeout", {31'd0, done}, 32'd1);
        if (cur_rd) exp_rd = rb;
        chk(rd_data == exp_rd, cur_rd ? "R7" : "R8", "rd_data at done", rd_data, exp_rd);
        @(negedge clk);
        chk(done == 1'b0 && done_cnt == 1, "R8", "single done pulse", done_cnt, 32'd1);
        chk(busy == 1'b0 && sdat_oe == 1'b1, "R6", "idle with line driven",
            {30'd0, busy, sdat_oe}, 32'd1);
        chk(rise_cnt == 34, "R3", "rising edge count", rise_cnt, 32'd34);
        bad_cmd = 0; bad_dat = 0; bad_oe = 0;
        for (int k = 0; k < 2; k++) begin
            if (rec_bit[k] !== cmd[k]) bad_cmd++;
            if (rec_oe[k] !== 1'b1) bad_oe++;
        end
        for (int k = 2; k < 34; k++) begin
            if (cur_rd) begin
                if (rec_oe[k] !== 1'b0) bad_oe++;
            end else begin
                if (rec_oe[k] !== 1'b1) bad_oe++;
                if (rec_bit[k] !== data[k-2]) bad_dat++;
            end
        end
        chk(bad_cmd == 0, "R3", "command bits LSB first", bad_cmd, 32'd0);
        chk(bad_dat == 0, "R5", "payload bits LSB first", bad_dat, 32'd0);
        chk(bad_oe == 0, "R6", "output enable per edge", bad_oe, 32'd0);
        // after an ignored request nothing else may start (R9)
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && rise_cnt == 34, "R9", "no extra frame", rise_cnt, 32'd34);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'h2b5e_11a7));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b0 && sdat_oe == 1'b1, "R10", "reset line state",
            {30'd0, sclk, sdat_oe}, 32'd1);
        chk(busy == 1'b0 && req_ready == 1'b1 && done == 1'b0, "R10", "reset handshake",
            {29'd0, busy, req_ready, done}, 32'd2);
        chk(rd_data == 32'd0, "R10", "reset rd_data", rd_data, 32'd0);

        // directed corners
        run_txn(2'b00, 32'hFFFF_FFFF, 0, 32'h0, 0);          // R11 clamp, send
        run_txn(2'b01, 32'h1234_5678, 1, 32'hA5C3_0F81, 0);  // R11 clamp, read
        run_txn(2'b10, 32'h0000_0000, 2, 32'h0, 1);          // R9 poke
        run_txn(2'b11, 32'hDEAD_BEEF, 7, 32'hFFFF_FFFF, 1);  // R5 payload dropped on read
        run_txn(2'b10, 32'h8000_0001, 3, 32'h0, 0);          // R8 rd_data kept
        run_txn(2'b11, 32'h0, 4, 32'h0000_0000, 0);

        for (int i = 0; i < 30; i++) begin
            run_txn(2'($urandom % 4), $urandom, int'($urandom % 8), $urandom,
                    ($urandom % 4) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end
endmodule